// File: doc/BRIEF.md
# Converter Wake and Command Sequencer

This block sits on the host side of a three-wire serial link to a multichannel ADC. It takes a one-byte conversion command, selects the converter, and waits for the converter's internal reference to settle only when that is needed. It then clocks the byte out serially and waits for the converter to signal that the conversion has finished. The caller sees a busy level while this runs, then a one-cycle completion pulse, or a one-cycle error pulse if the converter never answers.

The settling wait depends on the reference code in bits 2:1 of the command and on what the previous transfer left running. Codes 01 (reference and buffer both shut down while deselected) and 10 (buffer shut down while deselected) need a settling time. A parameter sets that time in system clocks. Code 00 keeps the reference running, and code 11 selects an external reference, so neither needs a wait. If the last transfer used code 00, the reference is still on and a following 01 or 10 request also starts at once. Raising chip-select again with code 01, 10 or 11 selected lets the converter drop its internal reference, so the next 01 or 10 request waits again.

Top module: `adc_wake_ctrl`

## Requirements
- R1: After reset, csN is high, sclk is low, and busy, done and err are all low.
- R2: A request is accepted only while busy is low. In the cycle after acceptance, csN is low and busy is high. A request raised while busy is high has no effect on the byte being sent, and it does not start a second transfer.
- R3: With reference code 01 or 10 (command bits 2:1) and the reference not awake, the first high level of sclk comes WAKE_CYCLES + SCLK_HALF + 1 cycles after the first cycle in which csN is low.
- R4: With reference code 00 or 11, the first high level of sclk comes SCLK_HALF + 1 cycles after the first cycle in which csN is low.
- R5: A transfer with code 00 leaves the reference awake, so the next request with code 01 or 10 starts without a wait (R4 timing). A transfer with code 01, 10 or 11 clears that state when csN rises.
- R6: Exactly eight sclk rising edges carry the command, most significant bit first. Bits 7:5 are the channel, bits 4:3 the scan mode, bits 2:1 the reference code and bit 0 the clock mode.
- R7: Every sclk high level and every low level between the first rise and the last fall lasts SCLK_HALF cycles. din changes only when sclk falls or while sclk is low, and it never changes while sclk stays high or as sclk rises.
- R8: After the eighth falling edge, the block waits for eocN low. done is high for exactly one cycle, in the cycle after eocN is first sampled low. In that same cycle csN is high and busy is low.
- R9: If eocN stays high, err pulses for one cycle EOC_TIMEOUT + 1 cycles after the cycle of the eighth falling edge. csN is high in that cycle and done does not pulse.
- R10: csN stays low from acceptance until the cycle in which done or err appears, and sclk is low whenever csN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start request, sampled while idle |
| reqCmd | input | 8 | Command byte to send |
| csN | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles low |
| din | output | 1 | Serial command data to the converter |
| eocN | input | 1 | End-of-conversion from the converter, active low |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the conversion has ended |
| err | output | 1 | One-cycle pulse when the end-of-conversion wait times out |

## Verification
Every result is registered, so each one is checked in a fixed cycle counted from the stimulus that causes it. csN and busy change one cycle after the request is sampled. The first sclk high comes SCLK_HALF + 1 cycles later, plus WAKE_CYCLES when a wait applies. done comes one cycle after eocN goes low, and err comes EOC_TIMEOUT + 1 cycles after the last sclk fall. The bench samples at the falling clock edge and numbers each sample from the request. It checks each of these counts exactly, not against a window, and it confirms that each pulse has gone in the following sample.

// File: rtl/adc_wake_pkg.sv
package adc_wake_pkg;

  localparam int CMD_W = 8;

  // reference / power-down codes held in command bits 2:1
  localparam logic [1:0] REF_KEEP_ON  = 2'b00;
  localparam logic [1:0] REF_ALL_OFF  = 2'b01;
  localparam logic [1:0] REF_BUF_OFF  = 2'b10;
  localparam logic [1:0] REF_EXTERNAL = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SHIFT,
    ST_EOC
  } wakeState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // take command, drop select, arm settle counter
    logic decWait;    // settle counter step
    logic loadShift;  // load shifter, park sclk low
    logic runShift;   // advance serial clock generator
    logic loadTo;     // arm end-of-conversion timeout
    logic decTo;      // timeout step
    logic csRise;     // deselect and update reference-awake state
  } wakeStrobe_t;

endpackage

// File: rtl/adc_wake_dp.sv
module adc_wake_dp
  import adc_wake_pkg::*;
#(
  parameter int WAKE_CYCLES = 500000,
  parameter int SCLK_HALF   = 4,
  parameter int EOC_TIMEOUT = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  wakeStrobe_t       stb,
  input  logic [CMD_W-1:0]  reqCmd,
  output logic              csN,
  output logic              sclk,
  output logic              din,
  output logic              waitZero,
  output logic              shiftDone,
  output logic              toZero
);

  localparam int WAIT_W = $clog2(WAKE_CYCLES + 1);
  localparam int HALF_W = $clog2(SCLK_HALF + 1);
  localparam int TO_W   = $clog2(EOC_TIMEOUT + 1);
  localparam int BIT_W  = $clog2(CMD_W);

  logic [CMD_W-1:0]  cmdReg;
  logic [CMD_W-1:0]  shiftReg;
  logic [WAIT_W-1:0] waitCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [TO_W-1:0]   toCnt;
  logic              sclkR;
  logic              csNR;
  logic              refAwake;
  logic              needWait;
  logic              halfEnd;

  // settling is needed for the shut-down codes unless the reference is still up
  assign needWait = ((reqCmd[2:1] == REF_ALL_OFF) || (reqCmd[2:1] == REF_BUF_OFF))
                    && !refAwake;
  assign halfEnd  = (halfCnt == HALF_W'(SCLK_HALF - 1));

  assign waitZero  = (waitCnt == '0);
  assign toZero    = (toCnt == '0);
  assign shiftDone = stb.runShift && halfEnd && sclkR
                     && (bitIdx == BIT_W'(CMD_W - 1));

  assign csN  = csNR;
  assign sclk = sclkR;
  assign din  = shiftReg[CMD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      shiftReg <= '0;
      waitCnt  <= '0;
      halfCnt  <= '0;
      bitIdx   <= '0;
      toCnt    <= '0;
      sclkR    <= 1'b0;
      csNR     <= 1'b1;
      refAwake <= 1'b0;
    end else begin
      if (stb.capture) begin
        cmdReg  <= reqCmd;
        waitCnt <= needWait ? WAIT_W'(WAKE_CYCLES) : '0;
        csNR    <= 1'b0;
      end
      if (stb.decWait) begin
        waitCnt <= waitCnt - 1'b1;
      end
      if (stb.loadShift) begin
        shiftReg <= cmdReg;
        sclkR    <= 1'b0;
        halfCnt  <= '0;
        bitIdx   <= '0;
      end
      if (stb.runShift) begin
        if (halfEnd) begin
          halfCnt <= '0;
          sclkR   <= ~sclkR;
          if (sclkR) begin
            // falling edge: present the next bit
            shiftReg <= {shiftReg[CMD_W-2:0], 1'b0};
            bitIdx   <= bitIdx + 1'b1;
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
      if (stb.loadTo) begin
        toCnt <= TO_W'(EOC_TIMEOUT);
      end
      if (stb.decTo) begin
        toCnt <= toCnt - 1'b1;
      end
      if (stb.csRise) begin
        csNR     <= 1'b1;
        refAwake <= (cmdReg[2:1] == REF_KEEP_ON);
      end
    end
  end

  // R10: serial clock parked low while deselected
  a_r10_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csNR |-> !sclkR);

  // R7: data held across a high serial clock phase
  a_r7_din_held_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclkR && $past(sclkR)) |-> $stable(shiftReg[CMD_W-1]));

  // R2: captured command untouched while selected
  a_r2_cmd_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!csNR && $past(!csNR)) |-> $stable(cmdReg));

  // R5: reference marked awake only after an always-on transfer
  a_r5_awake_from_keep_on: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refAwake) |-> ($past(cmdReg[2:1]) == REF_KEEP_ON));

endmodule

// File: rtl/adc_wake_fsm.sv
module adc_wake_fsm
  import adc_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        eocN,
  input  logic        waitZero,
  input  logic        shiftDone,
  input  logic        toZero,
  output wakeStrobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        err
);

  wakeState_t state, stateNext;
  logic       doneR, errR;
  logic       doneNext, errNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (waitZero) begin
          stb.loadShift = 1'b1;
          stateNext     = ST_SHIFT;
        end else begin
          stb.decWait = 1'b1;
        end
      end
      ST_SHIFT: begin
        stb.runShift = 1'b1;
        if (shiftDone) begin
          stb.loadTo = 1'b1;
          stateNext  = ST_EOC;
        end
      end
      ST_EOC: begin
        if (!eocN) begin
          doneNext   = 1'b1;
          stb.csRise = 1'b1;
          stateNext  = ST_IDLE;
        end else if (toZero) begin
          errNext    = 1'b1;
          stb.csRise = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          stb.decTo = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneR <= 1'b0;
      errR  <= 1'b0;
    end else begin
      state <= stateNext;
      doneR <= doneNext;
      errR  <= errNext;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;
  assign err  = errR;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: completion only follows a sampled end-of-conversion
  a_r8_done_after_eoc: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(!eocN));

  // R9: timeout is a single-cycle pulse, never together with completion
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rstN)
    err |=> !err);
  a_r9_err_excludes_done: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R2: an idle request always starts a transfer
  a_r2_accept_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

endmodule

// File: rtl/adc_wake_ctrl.sv
module adc_wake_ctrl
  import adc_wake_pkg::*;
#(
  parameter int WAKE_CYCLES = 500000,
  parameter int SCLK_HALF   = 4,
  parameter int EOC_TIMEOUT = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CMD_W-1:0] reqCmd,
  output logic             csN,
  output logic             sclk,
  output logic             din,
  input  logic             eocN,
  output logic             busy,
  output logic             done,
  output logic             err
);

  wakeStrobe_t stb;
  logic        waitZero;
  logic        shiftDone;
  logic        toZero;

  adc_wake_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .eocN      (eocN),
    .waitZero  (waitZero),
    .shiftDone (shiftDone),
    .toZero    (toZero),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  adc_wake_dp #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .SCLK_HALF   (SCLK_HALF),
    .EOC_TIMEOUT (EOC_TIMEOUT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqCmd    (reqCmd),
    .csN       (csN),
    .sclk      (sclk),
    .din       (din),
    .waitZero  (waitZero),
    .shiftDone (shiftDone),
    .toZero    (toZero)
  );

endmodule

// File: tb/sim_adc_wake_ctrl.sv
`timescale 1ns/1ps
module sim_adc_wake_ctrl;

  localparam int W = 20;
  localparam int H = 2;
  localparam int T = 30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqCmd = '0;
  logic       eocN = 1'b1;
  logic       csN, sclk, din, busy, done, err;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_wake_ctrl #(.WAKE_CYCLES(W), .SCLK_HALF(H), .EOC_TIMEOUT(T)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .csN(csN), .sclk(sclk), .din(din), .eocN(eocN),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // one full transfer, measured in falling-edge samples counted from the request
  task automatic runXfer(input string tag, input logic [7:0] cmd, input int expGap,
                         input int eocDelay, input bit inject);
    int idx = 1;
    int firstRise = -1;
    int falls = 0, rises = 0;
    int lastFall = -1, eocAt = -1, doneAt = -1, errAt = -1;
    int dinBad = 0, csBad = 0, runBad = 0, runLen = 0;
    bit injected = 0;
    bit csEnd = 0, busyEnd = 1;
    logic [7:0] got = '0;
    logic prevSclk, prevDin;
    @(negedge clk);
    reqValid = 1'b1;
    reqCmd = cmd;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2", {tag, " csN low after accept"}, int'(csN), 0);
    chk("R2", {tag, " busy after accept"}, int'(busy), 1);
    prevSclk = sclk;
    prevDin = din;
    while (doneAt < 0 && errAt < 0 && idx < 400) begin
      @(negedge clk);
      idx++;
      reqValid = 1'b0;
      if (sclk != prevSclk) begin
        if (firstRise >= 0 && runLen != H) runBad++;
        runLen = 1;
        if (sclk) begin
          if (firstRise < 0) firstRise = idx;
          rises++;
          got = {got[6:0], din};
          if (din != prevDin) dinBad++;
        end else begin
          falls++;
          if (falls == 8) lastFall = idx;
        end
      end else begin
        runLen++;
        if (sclk && din != prevDin) dinBad++;
      end
      if (done && doneAt < 0) begin doneAt = idx; csEnd = csN; busyEnd = busy; end
      if (err && errAt < 0) begin errAt = idx; csEnd = csN; busyEnd = busy; end
      if (doneAt < 0 && errAt < 0 && csN) csBad++;
      if (inject && !injected && rises == 3) begin
        reqValid = 1'b1;
        reqCmd = ~cmd;
        injected = 1;
      end
      if (lastFall >= 0 && eocDelay >= 0 && idx == lastFall + eocDelay) begin
        eocN = 1'b0;
        eocAt = idx;
      end
      prevSclk = sclk;
      prevDin = din;
    end
    eocN = 1'b1;
    @(negedge clk);
    chk("R8", {tag, " done gone next cycle"}, int'(done), 0);
    chk("R9", {tag, " err gone next cycle"}, int'(err), 0);
    chk(expGap > H + 1 ? "R3" : "R4", {tag, " select-to-first-sclk gap"}, firstRise - 1, expGap);
    chk("R6", {tag, " rising edge count"}, rises, 8);
    chk("R6", {tag, " bits shifted msb first"}, int'(got), int'(cmd));
    chk("R7", {tag, " sclk phase length errors"}, runBad, 0);
    chk("R7", {tag, " din changes outside low phase"}, dinBad, 0);
    chk("R10", {tag, " csN rose early"}, csBad, 0);
    chk("R10", {tag, " csN high at finish"}, int'(csEnd), 1);
    if (eocDelay >= 0) begin
      chk("R8", {tag, " done one cycle after eoc"}, doneAt - eocAt, 1);
      chk("R8", {tag, " busy low with done"}, int'(busyEnd), 0);
      chk("R8", {tag, " no err"}, errAt, -1);
    end else begin
      chk("R9", {tag, " timeout cycle"}, errAt - lastFall, T + 1);
      chk("R9", {tag, " no done on timeout"}, doneAt, -1);
    end
    if (inject) begin
      int stray = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (!csN || busy) stray++;
      end
      chk("R2", {tag, " busy-time request ignored"}, stray, 0);
    end
  endtask

  task automatic tReset();
    chk("R1", "csN after reset", int'(csN), 1);
    chk("R1", "sclk after reset", int'(sclk), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "err after reset", int'(err), 0);
  endtask

  task automatic tExternalRef();   // code 11: no wait (R4)
    runXfer("ext", 8'hA7, H + 1, 4, 0);
  endtask

  task automatic tColdWake();      // code 01 with reference asleep (R3)
    runXfer("cold01", 8'h6A, W + H + 1, 3, 0);
  endtask

  task automatic tBufOffWake();    // code 10 after a 01 deselect (R3, R5)
    runXfer("cold10", 8'hD5, W + H + 1, 6, 0);
  endtask

  task automatic tAwakeSkip();     // R5: keep-on leaves reference up
    runXfer("keepOn", 8'h31, H + 1, 2, 0);
    runXfer("warm01", 8'h8B, H + 1, 5, 0);
    runXfer("recold10", 8'h4C, W + H + 1, 1, 0);
  endtask

  task automatic tTimeout();       // R9
    runXfer("timeout", 8'h27, H + 1, -1, 0);
  endtask

  task automatic tBusyIgnore();    // R2
    runXfer("ignore", 8'h96, H + 1, 3, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExternalRef();
    tColdWake();
    tBufOffWake();
    tAwakeSkip();
    tTimeout();
    tBusyIgnore();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule